// File: doc/BRIEF.md
# Control Endpoint Halt-Status Register

This block keeps the halt (stall) state of a USB device's control endpoint. Firmware reaches it through an 8-bit register port. The USB engine reaches it through single-cycle request-decode strobes. Firmware can halt or un-halt the endpoint. The writes are gated by a NAK lock bit and by a busy flag that marks an access from the USB side. When the control transfer just finished was a feature request, a status request or a firmware-handled request, a firmware halt is not applied at once. It stays pending and commits at the next SETUP token.

The USB engine also changes the halt bit directly. It sets the bit on a decoded set-feature (endpoint halt) request and clears it on a clear-feature request. Each of these requests pulses a data-toggle reset. A status request is answered by the block itself with a two-byte reply. Every entry into the stalled state pulses a cleanup strobe, which flushes the endpoint buffers and its NAK flags.

A three-state machine holds the halt state:
- **ST_RUN**: not stalled, nothing pending.
- **ST_PEND**: not stalled, a firmware halt is waiting for a SETUP token.
- **ST_HALT**: stalled.

The transitions are:
- **RUN→HALT**: an immediate firmware halt, or a hardware set.
- **RUN→PEND**: a deferred firmware halt.
- **PEND→HALT**: a SETUP token arrives, or a hardware set.
- **PEND→RUN**: a firmware write of 0, or a hardware clear.
- **HALT→RUN**: a firmware write of 0, or a hardware clear.

Top module: `ep0_halt_status`

## Requirements
- R1: The register is 8 bits wide and only bit 0 is used; it holds the halt flag, where 1 means stalled and 0 means not stalled. Bits 7..1 always read 0. After reset the register reads 0x00 and all output strobes are low.
- R2: A firmware write (fw_wr_en high) is dropped unless nak_lock is 1 in the same cycle.
- R3: A firmware write is ignored while usb_busy is 1.
- R4: A defer window opens on any of req_set_halt, req_clr_halt, req_get_status or req_fw_handled, and it closes on setup_tok. Inside the window, an accepted write with bit 0 = 1 goes pending and commits at the next setup_tok. Outside the window it commits on the next clock edge.
- R5: An accepted write with bit 0 = 0 un-halts the endpoint on the next clock edge and discards any pending halt.
- R6: req_set_halt sets the halt bit and req_clr_halt clears it, each on the next clock edge. If both strobes are high in the same cycle, the clear takes effect.
- R7: toggle_rst pulses high for one cycle in the cycle after each req_set_halt or req_clr_halt.
- R8: stall_clean pulses high for one cycle each time the halt bit goes from 0 to 1, whether hardware or firmware caused it. It does not pulse when the endpoint is already halted.
- R9: In the cycle after req_get_status, status_valid is high for one cycle. status_reply then holds low byte = the register value in the request cycle and high byte = 0x00.
- R10: When setup_tok coincides with req_set_halt or req_clr_halt, the hardware request decides the halt bit and the pending firmware value is discarded.
- R11: fw_rdata shows the committed halt value, never the pending one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fw_wr_en | input | 1 | Firmware write strobe |
| fw_wdata | input | 8 | Firmware write data |
| nak_lock | input | 1 | NAK lock bit; a write is accepted only while this is 1 |
| usb_busy | input | 1 | USB side is accessing the control endpoint |
| setup_tok | input | 1 | SETUP token received |
| req_set_halt | input | 1 | Set-feature endpoint-halt request decoded |
| req_clr_halt | input | 1 | Clear-feature endpoint-halt request decoded |
| req_get_status | input | 1 | Get-status request to this endpoint decoded |
| req_fw_handled | input | 1 | Request handed to firmware |
| fw_rdata | output | 8 | Committed register value |
| status_valid | output | 1 | Status reply valid |
| status_reply | output | 16 | Two-byte status reply, low byte first |
| toggle_rst | output | 1 | Reset the endpoint data toggle to DATA0 |
| stall_clean | output | 1 | Clear the endpoint buffers and NAK flags |

## Verification
Two events can fall in the same cycle: the commit of a pending firmware halt at a SETUP token, and a hardware clear-feature or set-feature decode. The bench first parks the machine in ST_PEND by writing a halt after a status or firmware-handled request. It then raises setup_tok together with req_clr_halt. The pass condition is that the halt bit stays 0, toggle_rst pulses, and no stall_clean appears either then or on the following idle cycle. A second case withdraws a pending halt with a write of 0 before the token arrives.

// File: rtl/ep0_halt_pkg.sv
package ep0_halt_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_PEND = 2'd1,
        ST_HALT = 2'd2
    } ep0_st_e;
endpackage

// File: rtl/ep0_wr_gate.sv
module ep0_wr_gate #(
    parameter int REG_W    = 8,
    parameter int HALT_BIT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fw_wr_en,
    input  logic [REG_W-1:0] fw_wdata,
    input  logic             nak_lock,
    input  logic             usb_busy,
    input  logic             setup_tok,
    input  logic             req_set_halt,
    input  logic             req_clr_halt,
    input  logic             req_get_status,
    input  logic             req_fw_handled,
    output logic             wr_ok,
    output logic             wr_bit,
    output logic             defer_arm
);
    logic req_any;

    // a write counts only under the lock and with no USB-side access
    assign wr_ok   = fw_wr_en && nak_lock && !usb_busy;
    assign wr_bit  = fw_wdata[HALT_BIT];
    assign req_any = req_set_halt || req_clr_halt || req_get_status || req_fw_handled;

    // defer window: opened by a feature/status/firmware request, closed by SETUP
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            defer_arm <= 1'b0;
        else if (req_any)
            defer_arm <= 1'b1;
        else if (setup_tok)
            defer_arm <= 1'b0;
    end

    p_window_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_any |=> defer_arm);
    p_window_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_tok && !req_any) |=> !defer_arm);
endmodule

// File: rtl/ep0_halt_fsm.sv
module ep0_halt_fsm
    import ep0_halt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ok,
    input  logic wr_bit,
    input  logic defer_arm,
    input  logic setup_tok,
    input  logic hw_set,
    input  logic hw_clr,
    output logic halted,
    output logic pending,
    output logic toggle_rst,
    output logic stall_clean
);
    ep0_st_e st_q, st_d;
    logic    tog_d, cln_d;

    always_comb begin
        st_d  = st_q;
        tog_d = 1'b0;
        if (hw_clr) begin
            st_d  = ST_RUN;
            tog_d = 1'b1;
        end else if (hw_set) begin
            st_d  = ST_HALT;
            tog_d = 1'b1;
        end else begin
            unique case (st_q)
                ST_RUN:  if (wr_ok && wr_bit) st_d = defer_arm ? ST_PEND : ST_HALT;
                ST_PEND: if (wr_ok && !wr_bit) st_d = ST_RUN;
                         else if (setup_tok)   st_d = ST_HALT;
                ST_HALT: if (wr_ok && !wr_bit) st_d = ST_RUN;
                default: st_d = ST_RUN;
            endcase
        end
        cln_d = (st_d == ST_HALT) && (st_q != ST_HALT);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    // registered output strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            toggle_rst  <= 1'b0;
            stall_clean <= 1'b0;
        end else begin
            toggle_rst  <= tog_d;
            stall_clean <= cln_d;
        end
    end

    assign halted  = (st_q == ST_HALT);
    assign pending = (st_q == ST_PEND);

    p_hw_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hw_clr |=> !halted);
    p_hw_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set && !hw_clr) |=> halted);
    p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set || hw_clr) |=> toggle_rst);
    p_clean_on_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> stall_clean);
    p_no_clean_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> !stall_clean);
    p_pend_waits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !setup_tok && !hw_set && !hw_clr) |=> !halted);
    p_zero_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && !wr_bit && !hw_set) |=> (!halted && !pending));
endmodule

// File: rtl/ep0_status_reply.sv
module ep0_status_reply #(
    parameter int REG_W   = 8,
    parameter int REPLY_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_get_status,
    input  logic [REG_W-1:0]   reg_val,
    output logic               status_valid,
    output logic [REPLY_W-1:0] status_reply
);
    localparam int HI_W = REPLY_W - REG_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_valid <= 1'b0;
            status_reply <= '0;
        end else begin
            status_valid <= req_get_status;
            if (req_get_status)
                status_reply <= {{HI_W{1'b0}}, reg_val};
        end
    end

    p_reply_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_get_status |=> (status_valid && status_reply[REG_W-1:0] == $past(reg_val)
                            && status_reply[REPLY_W-1:REG_W] == '0));
    p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_get_status |=> !status_valid);
endmodule

// File: rtl/ep0_halt_status.sv
module ep0_halt_status #(
    parameter int REG_W    = 8,
    parameter int REPLY_W  = 16,
    parameter int HALT_BIT = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fw_wr_en,
    input  logic [REG_W-1:0]   fw_wdata,
    input  logic               nak_lock,
    input  logic               usb_busy,
    input  logic               setup_tok,
    input  logic               req_set_halt,
    input  logic               req_clr_halt,
    input  logic               req_get_status,
    input  logic               req_fw_handled,
    output logic [REG_W-1:0]   fw_rdata,
    output logic               status_valid,
    output logic [REPLY_W-1:0] status_reply,
    output logic               toggle_rst,
    output logic               stall_clean
);
    logic wr_ok, wr_bit, defer_arm, halted, pending;

    ep0_wr_gate #(.REG_W(REG_W), .HALT_BIT(HALT_BIT)) u_gate (
        .clk(clk), .rst_n(rst_n), .fw_wr_en(fw_wr_en), .fw_wdata(fw_wdata),
        .nak_lock(nak_lock), .usb_busy(usb_busy), .setup_tok(setup_tok),
        .req_set_halt(req_set_halt), .req_clr_halt(req_clr_halt),
        .req_get_status(req_get_status), .req_fw_handled(req_fw_handled),
        .wr_ok(wr_ok), .wr_bit(wr_bit), .defer_arm(defer_arm)
    );

    ep0_halt_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wr_bit(wr_bit),
        .defer_arm(defer_arm), .setup_tok(setup_tok),
        .hw_set(req_set_halt), .hw_clr(req_clr_halt),
        .halted(halted), .pending(pending),
        .toggle_rst(toggle_rst), .stall_clean(stall_clean)
    );

    // committed value only; unused bits read as zero
    always_comb begin
        fw_rdata           = '0;
        fw_rdata[HALT_BIT] = halted;
    end

    ep0_status_reply #(.REG_W(REG_W), .REPLY_W(REPLY_W)) u_reply (
        .clk(clk), .rst_n(rst_n), .req_get_status(req_get_status),
        .reg_val(fw_rdata), .status_valid(status_valid), .status_reply(status_reply)
    );

    p_unlocked_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_wr_en && !nak_lock && !setup_tok && !req_set_halt && !req_clr_halt)
        |=> $stable(fw_rdata));
    p_busy_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_wr_en && usb_busy && !setup_tok && !req_set_halt && !req_clr_halt)
        |=> $stable(fw_rdata));
    p_setup_hw_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_tok && req_clr_halt) |=> (fw_rdata[HALT_BIT] == 1'b0));
    p_pending_hidden_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> (fw_rdata == '0));
endmodule

// File: tb/ep0_halt_status_test.sv
`timescale 1ns/1ps
module ep0_halt_status_test;
    typedef struct packed {
        logic [7:0]  rd;
        logic        tog;
        logic        cln;
        logic        vld;
        logic [15:0] rep;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic fw_wr_en = 0, nak_lock = 0, usb_busy = 0, setup_tok = 0;
    logic req_set_halt = 0, req_clr_halt = 0, req_get_status = 0, req_fw_handled = 0;
    logic [7:0]  fw_wdata = '0;
    logic [7:0]  fw_rdata;
    logic        status_valid, toggle_rst, stall_clean;
    logic [15:0] status_reply;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_run = 0, n_fail = 0;
    bit    done = 0;

    always #2.5 clk = ~clk;

    ep0_halt_status uut (
        .clk(clk), .rst_n(rst_n), .fw_wr_en(fw_wr_en), .fw_wdata(fw_wdata),
        .nak_lock(nak_lock), .usb_busy(usb_busy), .setup_tok(setup_tok),
        .req_set_halt(req_set_halt), .req_clr_halt(req_clr_halt),
        .req_get_status(req_get_status), .req_fw_handled(req_fw_handled),
        .fw_rdata(fw_rdata), .status_valid(status_valid), .status_reply(status_reply),
        .toggle_rst(toggle_rst), .stall_clean(stall_clean)
    );

    // driver: one request cycle per call, expectation queued after the edge
    task automatic step(input logic wr, input logic [7:0] wd, input logic lk, input logic bz,
                        input logic su, input logic st, input logic cl, input logic gs,
                        input logic fh, input logic [7:0] erd, input logic etg,
                        input logic ecl, input logic evl, input logic [15:0] erp,
                        input string tag);
        exp_t e;
        @(negedge clk);
        fw_wr_en = wr; fw_wdata = wd; nak_lock = lk; usb_busy = bz; setup_tok = su;
        req_set_halt = st; req_clr_halt = cl; req_get_status = gs; req_fw_handled = fh;
        @(posedge clk);
        #1;
        e = '{rd: erd, tog: etg, cln: ecl, vld: evl, rep: erp};
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input logic [7:0] erd, input string tag);
        step(0, 8'h00, 0, 0, 0, 0, 0, 0, 0, erd, 0, 0, 0, 16'h0, tag);
    endtask

    // monitor: compare at the falling edge after the result edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_run++;
            if (fw_rdata !== e.rd || toggle_rst !== e.tog || stall_clean !== e.cln ||
                status_valid !== e.vld || (e.vld && status_reply !== e.rep)) begin
                n_fail++;
                $display("FAIL %s: rd=%h tog=%b cln=%b vld=%b rep=%h | exp rd=%h tog=%b cln=%b vld=%b rep=%h",
                         t, fw_rdata, toggle_rst, stall_clean, status_valid, status_reply,
                         e.rd, e.tog, e.cln, e.vld, e.rep);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: rd=%h exp=finished", fw_rdata);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        //   wr wd     lk bz su st cl gs fh  rd    tg cl vl rep
        idle(8'h00, "R1 reset value");
        step(1, 8'hFF, 0, 0, 0, 0, 0, 0, 0, 8'h00, 0, 0, 0, 16'h0, "R2 unlocked write dropped");
        step(1, 8'h01, 1, 1, 0, 0, 0, 0, 0, 8'h00, 0, 0, 0, 16'h0, "R3 busy write ignored");
        step(1, 8'hFF, 1, 0, 0, 0, 0, 0, 0, 8'h01, 0, 1, 0, 16'h0, "R1 R4 R8 immediate halt, upper bits zero");
        step(0, 8'h00, 0, 0, 0, 0, 0, 1, 0, 8'h01, 0, 0, 1, 16'h0001, "R9 status reply halted");
        step(1, 8'h00, 1, 0, 0, 0, 0, 0, 0, 8'h00, 0, 0, 0, 16'h0, "R5 write zero unhalts");
        step(1, 8'h01, 1, 0, 0, 0, 0, 0, 0, 8'h00, 0, 0, 0, 16'h0, "R4 R11 deferred halt hidden");
        idle(8'h00, "R11 pending stays hidden");
        step(0, 8'h00, 0, 0, 1, 0, 0, 0, 0, 8'h01, 0, 1, 0, 16'h0, "R4 R8 commit at setup");
        step(0, 8'h00, 0, 0, 0, 0, 1, 0, 0, 8'h00, 1, 0, 0, 16'h0, "R6 R7 hw clear");
        step(0, 8'h00, 0, 0, 0, 1, 0, 0, 0, 8'h01, 1, 1, 0, 16'h0, "R6 R7 R8 hw set");
        step(0, 8'h00, 0, 0, 0, 1, 0, 0, 0, 8'h01, 1, 0, 0, 16'h0, "R8 no clean when already halted");
        step(0, 8'h00, 0, 0, 0, 1, 1, 0, 0, 8'h00, 1, 0, 0, 16'h0, "R6 clear beats set");
        step(0, 8'h00, 0, 0, 1, 0, 0, 0, 0, 8'h00, 0, 0, 0, 16'h0, "R4 setup closes window");
        step(0, 8'h00, 0, 0, 0, 0, 0, 0, 1, 8'h00, 0, 0, 0, 16'h0, "R4 fw-handled opens window");
        step(1, 8'h01, 1, 0, 0, 0, 0, 0, 0, 8'h00, 0, 0, 0, 16'h0, "R4 R11 pending after fw request");
        step(0, 8'h00, 0, 0, 1, 0, 1, 0, 0, 8'h00, 1, 0, 0, 16'h0, "R10 hw clear wins over pending");
        idle(8'h00, "R10 pending discarded");
        step(0, 8'h00, 0, 0, 1, 0, 0, 0, 0, 8'h00, 0, 0, 0, 16'h0, "R4 window closed again");
        step(0, 8'h00, 0, 0, 0, 0, 0, 0, 1, 8'h00, 0, 0, 0, 16'h0, "R4 window reopened");
        step(1, 8'h01, 1, 0, 0, 0, 0, 0, 0, 8'h00, 0, 0, 0, 16'h0, "R4 pending again");
        step(0, 8'h00, 0, 0, 1, 1, 0, 0, 0, 8'h01, 1, 1, 0, 16'h0, "R10 hw set on setup boundary");
        step(1, 8'h00, 1, 0, 0, 0, 0, 0, 0, 8'h00, 0, 0, 0, 16'h0, "R5 unhalt");
        step(1, 8'h01, 1, 0, 0, 0, 0, 0, 0, 8'h00, 0, 0, 0, 16'h0, "R4 pending (window open)");
        step(1, 8'h00, 1, 0, 0, 0, 0, 0, 0, 8'h00, 0, 0, 0, 16'h0, "R5 zero cancels pending");
        step(0, 8'h00, 0, 0, 1, 0, 0, 0, 0, 8'h00, 0, 0, 0, 16'h0, "R5 nothing commits at setup");
        step(0, 8'h00, 0, 0, 0, 0, 0, 1, 0, 8'h00, 0, 0, 1, 16'h0000, "R9 status reply clear");
        idle(8'h00, "R9 valid is one cycle");
        repeat (3) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule